// File: doc/BRIEF.md
# Configurable NaN Classifier and Quieter

This block is purely combinational. It inspects one binary floating-point value in half, single or double precision and reports whether the value is a NaN. If it is, the block also says whether the NaN is quiet or signaling. It also produces three values:

- a quieted copy of the input;
- a "maybe-quiet" copy, which is changed only when the input is signaling;
- the default NaN pattern for the chosen format.

Different floating-point conventions disagree on several points:

- which level of the top fraction bit marks a quiet NaN;
- how a signaling NaN is made quiet;
- what the generated default NaN looks like.

Three inputs set these choices at run time: a polarity select, a convention select, and a mode that treats every NaN as quiet. A floating-point datapath places the block on its operand or result path, wherever NaNs must be recognised or silenced before they are propagated.

The value enters right-aligned in a 64-bit port. All outputs are right-aligned in the same way, with zeros above the active format width.

Top module: `nanq_unit`

## Requirements
- R1: `fmt_i` selects the format. Code 0 is half: bits 15:0, exponent 14:10, fraction 9:0. Code 1 is single: bits 31:0, exponent 30:23, fraction 22:0. Codes 2 and 3 are double: bits 63:0, exponent 62:52, fraction 51:0. Input bits above the active width have no effect on any output. Every 64-bit output is zero above that width.
- R2: A NaN has an all-ones exponent and a nonzero fraction. With `inv_pol_i`=0 and `all_quiet_i`=0, a NaN whose top fraction bit is 1 is quiet, and a NaN whose top fraction bit is 0 is signaling.
- R3: With `inv_pol_i`=1 and `all_quiet_i`=0, the two classes swap. A NaN with top fraction bit 1 is signaling, and a NaN with top fraction bit 0 (and some lower fraction bit set) is quiet.
- R4: With `all_quiet_i`=1, every NaN is reported quiet and `is_snan_o` is 0, whatever the polarity.
- R5: `conv_i` selects the default NaN; the patterns are listed per format as half / single / double.
  - Codes 0 and 3 give 7E00 / 7FC00000 / 7FF8000000000000 at normal polarity, and 7DFF / 7FBFFFFF / 7FF7FFFFFFFFFFFF at inverted polarity.
  - Code 1 gives FE00 / FFC00000 / FFF8000000000000 at normal polarity, and the same patterns as code 0 at inverted polarity.
  - Code 2 gives 7D00 / 7FA00000 / 7FF4000000000000 at either polarity.
- R6: At normal polarity, `quieted_o` is the input with its top fraction bit set.
- R7: At inverted polarity with `conv_i`=2, `quieted_o` is the input with the top fraction bit cleared and the next lower bit set. At inverted polarity with any other convention, `quieted_o` is the default NaN.
- R8: `maybe_quiet_o` equals `quieted_o` when `is_snan_o` is 1. Otherwise it equals the input, masked to the active width.
- R9: `is_qnan_o` and `is_snan_o` are never both 1. Their OR equals `is_nan_o`. A non-NaN value (zero, infinity, finite) sets neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt_i | input | 2 | Format select: 0 half, 1 single, 2 or 3 double |
| inv_pol_i | input | 1 | 1: a set top fraction bit marks a signaling NaN |
| conv_i | input | 2 | Default-NaN and quieting convention |
| all_quiet_i | input | 1 | Treat every NaN as quiet |
| value_i | input | DATA_W | Operand, right-aligned |
| is_nan_o | output | 1 | Operand is a NaN |
| is_qnan_o | output | 1 | Operand is a quiet NaN |
| is_snan_o | output | 1 | Operand is a signaling NaN |
| quieted_o | output | DATA_W | Operand after the quieting rule |
| maybe_quiet_o | output | DATA_W | Quieted if signaling, else the operand |
| default_nan_o | output | DATA_W | Default NaN of the selected format and convention |

## Verification
The block holds no state, so any fault shows at the ports in the same evaluation as the input that exposes it. Typical faults include a wrong field position, a swapped polarity test, or a misplaced default-pattern bit. A half-precision sweep covers every fraction under the all-ones exponent, in all sixteen mode combinations. Single and double precision get walking-one fractions. These stimuli catch a classification fault at the exact boundary between infinity, quiet and signaling. A width or masking fault shows up as nonzero upper output bits, because the unused input bits carry a fixed nonzero pattern.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_DBL_B  = 2'd3
  } nanq_fmt_e;

  typedef enum logic [1:0] {
    CONV_PLAIN   = 2'd0,
    CONV_SIGNED  = 2'd1,
    CONV_SHIFTQ  = 2'd2,
    CONV_PLAIN_B = 2'd3
  } nanq_conv_e;

  typedef struct packed {
    logic is_nan;
    logic quiet;
    logic sig;
  } nanq_class_t;

  localparam int unsigned NUM_FMT = 3;

  function automatic int unsigned exp_bits(input int unsigned idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int unsigned frac_bits(input int unsigned idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic logic [1:0] fmt_lane(input logic [1:0] fmt);
    case (fmt)
      FMT_HALF:   return 2'd0;
      FMT_SINGLE: return 2'd1;
      default:    return 2'd2;
    endcase
  endfunction

  function automatic nanq_class_t classify(input logic exp_full,
                                           input logic top_set,
                                           input logic rest_nz,
                                           input logic inv_pol,
                                           input logic all_quiet);
    nanq_class_t c;
    logic top_nan;
    logic low_nan;
    top_nan  = exp_full & top_set;
    low_nan  = exp_full & ~top_set & rest_nz;
    c.is_nan = top_nan | low_nan;
    if (all_quiet) begin
      c.quiet = c.is_nan;
      c.sig   = 1'b0;
    end else if (inv_pol) begin
      c.quiet = low_nan;
      c.sig   = top_nan;
    end else begin
      c.quiet = top_nan;
      c.sig   = low_nan;
    end
    return c;
  endfunction

endpackage

// File: rtl/nanq_classify.sv
module nanq_classify
  import nanq_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val_i,
  input  logic         inv_pol_i,
  input  logic         all_quiet_i,
  output nanq_class_t  cls_o,
  output logic         exp_full_o,
  output logic         top_set_o
);

  logic [EXP_W-1:0]  exp_field;
  logic [FRAC_W-1:0] frac_field;
  logic              rest_nz;

  assign exp_field  = val_i[W-2 -: EXP_W];
  assign frac_field = val_i[FRAC_W-1:0];
  assign exp_full_o = &exp_field;
  assign top_set_o  = frac_field[FRAC_W-1];
  assign rest_nz    = |frac_field[FRAC_W-2:0];

  assign cls_o = classify(exp_full_o, top_set_o, rest_nz, inv_pol_i, all_quiet_i);

endmodule

// File: rtl/nanq_default.sv
module nanq_default
  import nanq_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic       inv_pol_i,
  input  nanq_conv_e conv_i,
  output logic [W-1:0] dflt_o
);

  localparam logic [W-1:0] EXP_ONES = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] TOP_BIT  = {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] NEXT_BIT = TOP_BIT >> 1;
  localparam logic [W-1:0] LOW_ALL  = TOP_BIT - 1'b1;
  localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    case (conv_i)
      CONV_SHIFTQ: dflt_o = EXP_ONES | NEXT_BIT;
      CONV_SIGNED: dflt_o = inv_pol_i ? (EXP_ONES | LOW_ALL)
                                      : (SIGN_BIT | EXP_ONES | TOP_BIT);
      default:     dflt_o = inv_pol_i ? (EXP_ONES | LOW_ALL)
                                      : (EXP_ONES | TOP_BIT);
    endcase
  end

endmodule

// File: rtl/nanq_quiet.sv
module nanq_quiet
  import nanq_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val_i,
  input  logic         inv_pol_i,
  input  nanq_conv_e   conv_i,
  input  logic [W-1:0] dflt_i,
  output logic [W-1:0] quiet_o
);

  localparam logic [W-1:0] TOP_BIT  = {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] NEXT_BIT = TOP_BIT >> 1;

  always_comb begin
    if (!inv_pol_i)                quiet_o = val_i | TOP_BIT;
    else if (conv_i == CONV_SHIFTQ) quiet_o = (val_i & ~TOP_BIT) | NEXT_BIT;
    else                           quiet_o = dflt_i;
  end

endmodule

// File: rtl/nanq_unit.sv
module nanq_unit
  import nanq_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [1:0]        fmt_i,
  input  logic              inv_pol_i,
  input  logic [1:0]        conv_i,
  input  logic              all_quiet_i,
  input  logic [DATA_W-1:0] value_i,
  output logic              is_nan_o,
  output logic              is_qnan_o,
  output logic              is_snan_o,
  output logic [DATA_W-1:0] quieted_o,
  output logic [DATA_W-1:0] maybe_quiet_o,
  output logic [DATA_W-1:0] default_nan_o
);

  nanq_conv_e        conv;
  nanq_class_t       lane_cls   [NUM_FMT];
  logic [DATA_W-1:0] lane_val   [NUM_FMT];
  logic [DATA_W-1:0] lane_dflt  [NUM_FMT];
  logic [DATA_W-1:0] lane_quiet [NUM_FMT];
  logic [NUM_FMT-1:0] lane_exp_full;
  logic [NUM_FMT-1:0] lane_top_set;
  logic [1:0]        sel;
  nanq_class_t       sel_cls;

  assign conv = nanq_conv_e'(conv_i);

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    localparam int unsigned EW = exp_bits(g);
    localparam int unsigned FW = frac_bits(g);
    localparam int unsigned LW = 1 + EW + FW;

    logic [LW-1:0] v_w;
    logic [LW-1:0] d_w;
    logic [LW-1:0] q_w;

    assign v_w = value_i[LW-1:0];

    nanq_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls (
      .val_i       (v_w),
      .inv_pol_i   (inv_pol_i),
      .all_quiet_i (all_quiet_i),
      .cls_o       (lane_cls[g]),
      .exp_full_o  (lane_exp_full[g]),
      .top_set_o   (lane_top_set[g])
    );

    nanq_default #(.EXP_W(EW), .FRAC_W(FW)) u_dflt (
      .inv_pol_i (inv_pol_i),
      .conv_i    (conv),
      .dflt_o    (d_w)
    );

    nanq_quiet #(.EXP_W(EW), .FRAC_W(FW)) u_quiet (
      .val_i     (v_w),
      .inv_pol_i (inv_pol_i),
      .conv_i    (conv),
      .dflt_i    (d_w),
      .quiet_o   (q_w)
    );

    assign lane_val[g]   = DATA_W'(v_w);
    assign lane_dflt[g]  = DATA_W'(d_w);
    assign lane_quiet[g] = DATA_W'(q_w);
  end

  assign sel     = fmt_lane(fmt_i);
  assign sel_cls = lane_cls[sel];

  assign is_nan_o      = sel_cls.is_nan;
  assign is_qnan_o     = sel_cls.quiet;
  assign is_snan_o     = sel_cls.sig;
  assign quieted_o     = lane_quiet[sel];
  assign default_nan_o = lane_dflt[sel];
  assign maybe_quiet_o = sel_cls.sig ? lane_quiet[sel] : lane_val[sel];

endmodule

// File: rtl/nanq_checker.sv
module nanq_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic [1:0]        fmt_i,
  input logic              all_quiet_i,
  input logic [DATA_W-1:0] value_i,
  input logic              is_nan_o,
  input logic              is_qnan_o,
  input logic              is_snan_o,
  input logic [DATA_W-1:0] quieted_o,
  input logic [DATA_W-1:0] maybe_quiet_o,
  input logic [DATA_W-1:0] default_nan_o
);

  logic [DATA_W-1:0] width_mask;

  always_comb begin
    case (fmt_i)
      2'd0:    width_mask = DATA_W'(16'hFFFF);
      2'd1:    width_mask = DATA_W'(32'hFFFF_FFFF);
      default: width_mask = '1;
    endcase
  end

  always_comb begin
    a_r9_exclusive: assert (!(is_qnan_o && is_snan_o))
      else $error("quiet and signaling both set");
    a_r9_nan_union: assert ((is_qnan_o || is_snan_o) == is_nan_o)
      else $error("class flags disagree with NaN flag");
    a_r4_no_signal: assert (!all_quiet_i || !is_snan_o)
      else $error("signaling reported in all-quiet mode");
    a_r8_passthru: assert (is_snan_o || maybe_quiet_o == (value_i & width_mask))
      else $error("maybe-quiet altered a non-signaling value");
    a_r8_uses_quiet: assert (!is_snan_o || maybe_quiet_o == quieted_o)
      else $error("maybe-quiet differs from quieted copy on signaling input");
    a_r1_upper_zero: assert (((quieted_o | default_nan_o | maybe_quiet_o) & ~width_mask) == '0)
      else $error("output bits above format width");
  end

endmodule

bind nanq_unit nanq_checker #(.DATA_W(DATA_W)) u_nanq_checker (
  .fmt_i         (fmt_i),
  .all_quiet_i   (all_quiet_i),
  .value_i       (value_i),
  .is_nan_o      (is_nan_o),
  .is_qnan_o     (is_qnan_o),
  .is_snan_o     (is_snan_o),
  .quieted_o     (quieted_o),
  .maybe_quiet_o (maybe_quiet_o),
  .default_nan_o (default_nan_o)
);

// File: tb/nanq_unit_bench.sv
module nanq_unit_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0;

  logic [1:0]  fmt;
  logic        pol;
  logic [1:0]  conv;
  logic        aq;
  logic [63:0] val;
  logic        is_nan, is_q, is_s;
  logic [63:0] qt, mb, dn;

  nanq_unit u_nanq_unit (
    .fmt_i (fmt), .inv_pol_i (pol), .conv_i (conv), .all_quiet_i (aq),
    .value_i (val), .is_nan_o (is_nan), .is_qnan_o (is_q), .is_snan_o (is_s),
    .quieted_o (qt), .maybe_quiet_o (mb), .default_nan_o (dn)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s fmt=%0d pol=%0d conv=%0d aq=%0d val=%h: got %h expected %h",
               req, what, fmt, pol, conv, aq, val, got, exp);
    end
  endtask

  // Independent arithmetic model of the requirements.
  task automatic model(input logic [1:0] f_c, input logic p, input logic [1:0] c,
                       input logic a, input logic [63:0] raw,
                       output logic e_nan, output logic e_q, output logic e_s,
                       output logic [63:0] e_dn, output logic [63:0] e_qt,
                       output logic [63:0] e_mb, output logic [63:0] e_mask);
    int e, fr, w;
    logic [63:0] v, ones, top, sgn, fmask;
    logic hi;
    case (f_c)
      2'd0: begin e = 5;  fr = 10; end
      2'd1: begin e = 8;  fr = 23; end
      default: begin e = 11; fr = 52; end
    endcase
    w      = 1 + e + fr;
    e_mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    v      = raw & e_mask;
    ones   = ((64'd1 << e) - 64'd1) << fr;
    top    = 64'd1 << (fr - 1);
    sgn    = 64'd1 << (w - 1);
    fmask  = (64'd1 << fr) - 64'd1;
    e_nan  = ((v & ones) == ones) && ((v & fmask) != 0);
    hi     = (v & top) != 0;
    if (a) begin
      e_q = e_nan; e_s = 1'b0;
    end else if (!p) begin
      e_q = e_nan && hi; e_s = e_nan && !hi;
    end else begin
      e_q = e_nan && !hi; e_s = e_nan && hi;
    end
    if (c == 2'd2)      e_dn = ones | (top >> 1);
    else if (p)         e_dn = ones | (top - 64'd1);
    else if (c == 2'd1) e_dn = sgn | ones | top;
    else                e_dn = ones | top;
    if (!p)             e_qt = v | top;
    else if (c == 2'd2) e_qt = (v & ~top) | (top >> 1);
    else                e_qt = e_dn;
    e_mb = e_s ? e_qt : v;
  endtask

  task automatic run_vec(input logic [1:0] f_c, input logic p, input logic [1:0] c,
                         input logic a, input logic [63:0] raw);
    logic e_nan, e_q, e_s;
    logic [63:0] e_dn, e_qt, e_mb, e_mask;
    @(posedge clk);
    #1;
    fmt = f_c; pol = p; conv = c; aq = a; val = raw;
    #3;
    model(f_c, p, c, a, raw, e_nan, e_q, e_s, e_dn, e_qt, e_mb, e_mask);
    if (a)      chk("R4", "classes", {62'd0, is_q, is_s}, {62'd0, e_q, e_s});
    else if (p) chk("R3", "classes", {62'd0, is_q, is_s}, {62'd0, e_q, e_s});
    else        chk("R2", "classes", {62'd0, is_q, is_s}, {62'd0, e_q, e_s});
    chk("R2", "is_nan", {63'd0, is_nan}, {63'd0, e_nan});
    chk("R9", "exclusive", {63'd0, is_q & is_s}, 64'd0);
    chk("R5", "default", dn, e_dn);
    if (!p) chk("R6", "quieted", qt, e_qt);
    else    chk("R7", "quieted", qt, e_qt);
    chk("R8", "maybe", mb, e_mb);
    if (f_c < 2) chk("R1", "upper bits", (qt | mb | dn) & ~e_mask, 64'd0);
  endtask

  initial begin
    fmt = 2'd0; pol = 1'b0; conv = 2'd0; aq = 1'b0; val = '0;
    repeat (3) @(posedge clk);
    #4;
    chk("R9", "reset zero class", {61'd0, is_nan, is_q, is_s}, 64'd0);
    chk("R5", "reset default", dn, 64'h7E00);
    rst_n = 1'b1;

    // Half: every fraction under the all-ones exponent, all modes.
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int fr = 0; fr < 1024; fr++) begin
          run_vec(2'd0, cfg[0], cfg[2:1], cfg[3],
                  {48'hA5A5_5A5A_C3C3, sg[0], 5'h1F, fr[9:0]});
        end
        run_vec(2'd0, cfg[0], cfg[2:1], cfg[3], {48'hFFFF_0000_1234, sg[0], 15'h0000});
        run_vec(2'd0, cfg[0], cfg[2:1], cfg[3], {48'h0, sg[0], 5'h1E, 10'h3FF});
        run_vec(2'd0, cfg[0], cfg[2:1], cfg[3], {48'h0, sg[0], 5'h0F, 10'h200});
      end
    end

    // Single and double (both codes): walking-one fractions and specials.
    for (int fc = 1; fc < 4; fc++) begin
      for (int cfg = 0; cfg < 16; cfg++) begin
        for (int sg = 0; sg < 2; sg++) begin
          int e, f;
          logic [63:0] ones, sgnb, junk;
          e    = (fc == 1) ? 8 : 11;
          f    = (fc == 1) ? 23 : 52;
          ones = ((64'd1 << e) - 64'd1) << f;
          sgnb = sg[0] ? (64'd1 << (e + f)) : 64'd0;
          junk = (fc == 1) ? 64'h9E37_79B9_0000_0000 : 64'd0;
          for (int k = 0; k < f; k++)
            run_vec(fc[1:0], cfg[0], cfg[2:1], cfg[3], junk | sgnb | ones | (64'd1 << k));
          run_vec(fc[1:0], cfg[0], cfg[2:1], cfg[3], junk | sgnb | ones);
          run_vec(fc[1:0], cfg[0], cfg[2:1], cfg[3], junk | sgnb | ones | ((64'd1 << f) - 64'd1));
          run_vec(fc[1:0], cfg[0], cfg[2:1], cfg[3], junk | sgnb | ones | (64'd3 << (f - 2)));
          run_vec(fc[1:0], cfg[0], cfg[2:1], cfg[3], junk | sgnb | (64'd1 << f) | 64'd5);
          run_vec(fc[1:0], cfg[0], cfg[2:1], cfg[3], junk | sgnb);
        end
      end
    end

    finish_run();
  end

endmodule